// File: doc/BRIEF.md
# Multiplexed LCD Common/Segment Drive Sequencer

This block drives a multiplexed liquid-crystal panel with up to four common lines and 32 segment lines. It runs from a slow timebase, given as a one-cycle enable pulse from a 32.768 kHz oscillator. A small pixel store holds four bits per segment, one bit per common. The host reaches the store through two registers. The first is a segment pointer. The second is a 4-bit data window onto the entry that the pointer selects.

While the block is on, it steps through the active commons one time slot at a time. Duty can be 1/2, 1/3 or 1/4. The slot length comes from a per-duty table of four divisors, so that the frame rate stays between roughly 54 Hz and 71 Hz at every duty.

Each common and segment pin gets a 2-bit level code. An external bias network turns each code into a voltage. Drive polarity can alternate on every slot (A-type) or once per frame (B-type), so that the panel sees no DC component. When the block is off, every pin is held at ground.

Top module: `lcd_mux_ctrl`

## Requirements
- R1: After reset the pointer reads 0x00, the data window reads 0x00, and every common and segment level code is 2'b00.
- R2: While `lcd_on` is 0, every common and segment level code is 2'b00, whatever the pixel store holds.
- R3: With `duty` = 00 (two commons), `rate_sel` values 00/01/10/11 give slots of 256/280/304/232 timebase ticks, and a frame is two slots.
- R4: With `duty` = 01 (three commons), `rate_sel` values 00/01/10/11 give slots of 172/188/204/156 ticks, and a frame is three slots.
- R5: With `duty` = 10 or 11 (four commons), `rate_sel` values 00/01/10/11 give slots of 128/140/152/116 ticks, and a frame is four slots.
- R6: Common level codes follow the polarity. With polarity positive, the active common is 2'b11 and every other common is 2'b01. With polarity negative, the active common is 2'b00 and every other common is 2'b10. A common beyond the selected duty always counts as inactive.
- R7: Segment level codes depend on the pixel bit for the active common. With polarity positive, a lit pixel gives 2'b00 and an unlit pixel gives 2'b10. With polarity negative, a lit pixel gives 2'b11 and an unlit pixel gives 2'b01.
- R8: With `wave_b` = 0 (A-type), polarity inverts at every slot boundary.
- R9: With `wave_b` = 1 (B-type), polarity inverts only when the last active common's slot ends, and stays unchanged at every other slot boundary.
- R10: A pointer write keeps only bits 4:0 of `ptr_wdata`. The pointer reads back with bits 7:5 at zero.
- R11: A data write stores `dat_wdata[3:0]` at the entry the pointer selects, with bit n belonging to common n. The data window reads {4'b0, stored bits}.
- R12: When `lcd_on` rises, the sequence starts at common 0 with positive polarity, and common 0 holds for a full slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sub_tick | input | 1 | One-cycle pulse at the 32.768 kHz timebase rate |
| lcd_on | input | 1 | Display enable |
| duty | input | 2 | 00: 1/2, 01: 1/3, 1x: 1/4 duty |
| rate_sel | input | 2 | Frame-rate divisor select |
| wave_b | input | 1 | 0: A-type polarity per slot, 1: B-type per frame |
| ptr_we | input | 1 | Pointer write strobe |
| ptr_wdata | input | 8 | Pointer write data |
| dat_we | input | 1 | Data window write strobe |
| dat_wdata | input | 8 | Data window write data |
| ptr_rdata | output | 8 | Pointer read value |
| dat_rdata | output | 8 | Pixel bits at the pointer |
| com_lvl | output | 8 | Level code for common c at bits 2c+1:2c |
| seg_lvl | output | 64 | Level code for segment s at bits 2s+1:2s |

## Verification
The rarest state to reach from the pins is a B-type frame boundary, since polarity changes only after the last active common's slot has run out. The longest slots last hundreds of ticks. The bench holds `sub_tick` high on every clock so that a full frame takes a few hundred cycles. It then counts edges from the rise of `lcd_on`, which puts each sample one cycle before and one cycle after the expected boundary. Pixel patterns that alternate from common to common make the segment codes change at every slot, so that slots and polarity changes can be seen in the segment codes as well as the common codes.

// File: rtl/lcd_mux_ctrl.sv
module lcd_mux_ctrl #(
  parameter int NSEG = 32,
  parameter int NCOM = 4,
  parameter int CNTW = 9,
  localparam int PW  = $clog2(NSEG),
  localparam int CIW = $clog2(NCOM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sub_tick,
  input  logic              lcd_on,
  input  logic [1:0]        duty,
  input  logic [1:0]        rate_sel,
  input  logic              wave_b,
  input  logic              ptr_we,
  input  logic [7:0]        ptr_wdata,
  input  logic              dat_we,
  input  logic [7:0]        dat_wdata,
  output logic [7:0]        ptr_rdata,
  output logic [7:0]        dat_rdata,
  output logic [2*NCOM-1:0] com_lvl,
  output logic [2*NSEG-1:0] seg_lvl
);

  logic [PW-1:0]   ptr;
  logic [NCOM-1:0] pix [NSEG];
  logic [CNTW-1:0] cnt, slot_len;
  logic [CIW-1:0]  com_idx, last_com;
  logic            neg;

  always_comb begin
    case ({duty, rate_sel})
      4'b0000: slot_len = CNTW'(256);
      4'b0001: slot_len = CNTW'(280);
      4'b0010: slot_len = CNTW'(304);
      4'b0011: slot_len = CNTW'(232);
      4'b0100: slot_len = CNTW'(172);
      4'b0101: slot_len = CNTW'(188);
      4'b0110: slot_len = CNTW'(204);
      4'b0111: slot_len = CNTW'(156);
      default:
        case (rate_sel)
          2'b00:   slot_len = CNTW'(128);
          2'b01:   slot_len = CNTW'(140);
          2'b10:   slot_len = CNTW'(152);
          default: slot_len = CNTW'(116);
        endcase
    endcase
  end

  assign last_com = (duty == 2'b00) ? CIW'(1) : (duty == 2'b01) ? CIW'(2) : CIW'(3);

  wire slot_end  = sub_tick && (cnt >= slot_len - CNTW'(1));
  wire frame_end = slot_end && (com_idx >= last_com);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; com_idx <= '0; neg <= 1'b0;
    end else if (!lcd_on) begin
      cnt <= '0; com_idx <= '0; neg <= 1'b0;
    end else if (slot_end) begin
      cnt     <= '0;
      com_idx <= frame_end ? '0 : com_idx + CIW'(1);
      if (!wave_b || frame_end) neg <= ~neg;
    end else if (sub_tick) begin
      cnt <= cnt + CNTW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      for (int s = 0; s < NSEG; s++) pix[s] <= '0;
    end else begin
      if (ptr_we) ptr <= ptr_wdata[PW-1:0];
      if (dat_we) pix[ptr] <= dat_wdata[NCOM-1:0];
    end
  end

  assign ptr_rdata = 8'(ptr);
  assign dat_rdata = 8'(pix[ptr]);

  logic [NCOM-1:0] com_ext;

  for (genvar c = 0; c < NCOM; c++) begin : g_com
    assign com_lvl[2*c +: 2] = !lcd_on ? 2'b00 :
                               (com_idx == CIW'(c)) ? (neg ? 2'b00 : 2'b11) :
                                                      (neg ? 2'b10 : 2'b01);
    assign com_ext[c] = (com_lvl[2*c +: 2] == 2'b11) || (com_lvl[2*c +: 2] == 2'b00);
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    wire lit = pix[s][com_idx];
    assign seg_lvl[2*s +: 2] = !lcd_on ? 2'b00 :
                               lit ? (neg ? 2'b11 : 2'b00) : (neg ? 2'b01 : 2'b10);
  end

  a_r6_one_active_com: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_on |-> $countones(com_ext) == 1);

  a_r5_com_within_duty: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_on |-> com_idx <= last_com);

  a_r12_start_com0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_on) |-> (com_idx == '0 && cnt == '0 && !neg));

  a_r9_b_hold_mid_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_on && wave_b && !frame_end) |=> (!lcd_on || $stable(neg)));

  a_r8_a_flip_each_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_on && !wave_b && slot_end) |=> (!lcd_on || neg != $past(neg)));

  a_r2_off_ground: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_on |-> (com_ext == '1 && seg_lvl == '0));

endmodule

// File: tb/lcd_mux_ctrl_test.sv
module lcd_mux_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sub_tick = 1'b1, lcd_on = 1'b0, wave_b = 1'b1;
  logic [1:0] duty = 2'b00, rate_sel = 2'b00;
  logic ptr_we = 1'b0, dat_we = 1'b0;
  logic [7:0] ptr_wdata = '0, dat_wdata = '0;
  logic [7:0] ptr_rdata, dat_rdata;
  logic [7:0] com_lvl;
  logic [63:0] seg_lvl;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lcd_mux_ctrl uut (.*);

  // {duty, rate_sel, slot length}
  localparam logic [13:0] VEC [12] = '{
    {2'd0, 2'd0, 10'd256}, {2'd0, 2'd1, 10'd280}, {2'd0, 2'd2, 10'd304}, {2'd0, 2'd3, 10'd232},
    {2'd1, 2'd0, 10'd172}, {2'd1, 2'd1, 10'd188}, {2'd1, 2'd2, 10'd204}, {2'd1, 2'd3, 10'd156},
    {2'd2, 2'd0, 10'd128}, {2'd3, 2'd1, 10'd140}, {2'd2, 2'd2, 10'd152}, {2'd3, 2'd3, 10'd116}};

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_ptr(logic [7:0] v);
    ptr_wdata = v; ptr_we = 1'b1; step(1); ptr_we = 1'b0;
  endtask

  task automatic wr_dat(logic [7:0] v);
    dat_wdata = v; dat_we = 1'b1; step(1); dat_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(2);
    chk("R1 com", 64'(com_lvl), 64'h0);
    chk("R1 seg", seg_lvl, 64'h0);
    chk("R1 ptr", 64'(ptr_rdata), 64'h0);
    chk("R1 dat", 64'(dat_rdata), 64'h0);
    rst_n = 1'b1;
    step(1);

    wave_b = 1'b1;
    for (int i = 0; i < 12; i++) begin
      lcd_on = 1'b0; duty = VEC[i][13:12]; rate_sel = VEC[i][11:10];
      step(1);
      lcd_on = 1'b1;
      step(int'(VEC[i][9:0]) - 1);
      chk($sformatf("R3/R4/R5 slot0 v%0d", i), 64'(com_lvl[1:0]), 64'h3);
      step(1);
      chk($sformatf("R3/R4/R5 slot1 v%0d", i), 64'(com_lvl[3:0]), 64'hD);
    end
    lcd_on = 1'b0;
    step(1);

    wr_ptr(8'hFF);
    chk("R10 ptr mask", 64'(ptr_rdata), 64'h1F);
    wr_ptr(8'h05);
    wr_dat(8'hFA);
    chk("R11 dat read", 64'(dat_rdata), 64'h0A);
    wr_ptr(8'h00);
    wr_dat(8'h05);
    chk("R11 dat seg0", 64'(dat_rdata), 64'h05);
    wr_ptr(8'h05);
    chk("R11 seg5 kept", 64'(dat_rdata), 64'h0A);

    chk("R2 off com", 64'(com_lvl), 64'h0);
    chk("R2 off seg", seg_lvl, 64'h0);

    // A-type, 1/4 duty, 116-tick slots
    duty = 2'b10; rate_sel = 2'b11; wave_b = 1'b0;
    lcd_on = 1'b1;
    step(1);
    chk("R12 start com", 64'(com_lvl), 64'h57);
    chk("R7 seg0 lit pos", 64'(seg_lvl[1:0]), 64'h0);
    chk("R7 seg1 unlit pos", 64'(seg_lvl[3:2]), 64'h2);
    chk("R7 seg5 unlit c0", 64'(seg_lvl[11:10]), 64'h2);
    step(115);
    chk("R8 slot1 neg com", 64'(com_lvl), 64'hA2);
    chk("R7 seg0 unlit neg", 64'(seg_lvl[1:0]), 64'h1);
    chk("R7 seg5 lit neg", 64'(seg_lvl[11:10]), 64'h3);
    step(116);
    chk("R8 slot2 pos com", 64'(com_lvl), 64'h75);
    chk("R7 seg0 lit c2", 64'(seg_lvl[1:0]), 64'h0);

    lcd_on = 1'b0;
    step(1);
    chk("R2 off after run", seg_lvl, 64'h0);

    // B-type, 1/2 duty, 232-tick slots
    duty = 2'b00; wave_b = 1'b1;
    lcd_on = 1'b1;
    step(1);
    chk("R12 restart", 64'(com_lvl), 64'h57);
    step(231);
    chk("R9 slot1 still pos", 64'(com_lvl), 64'h5D);
    chk("R6 beyond duty inactive", 64'(com_lvl[7:4]), 64'h5);
    step(232);
    chk("R9 frame flip", 64'(com_lvl), 64'hA8);
    step(232);
    chk("R9 mid frame hold", 64'(com_lvl), 64'hA2);

    // a stalled timebase holds the slot
    sub_tick = 1'b0;
    step(600);
    chk("R3 no tick hold", 64'(com_lvl), 64'hA2);
    sub_tick = 1'b1;

    // re-enable mid-frame
    lcd_on = 1'b0;
    step(3);
    lcd_on = 1'b1;
    step(1);
    chk("R12 re-enable com0", 64'(com_lvl), 64'h57);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule